// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block merges the eight interrupt requests of a two-channel serial controller into the single active-low interrupt line of an 8-bit CPU. Each channel has four sources: transmit-holding empty, status change, receive data and external or modem event. When the CPU answers the interrupt, the block supplies a one-byte vector on the data bus during the acknowledge cycle. The vector points at that source's entry in a table of two-byte handler addresses in CPU memory.

The CPU does not have a dedicated acknowledge pin. The block therefore decodes the acknowledge cycle from the CPU bus strobes. It picks the winner by a fixed priority and freezes that choice for the whole acknowledge cycle. It then hides the acknowledged source until that source's request line falls, so one event raises only one interrupt.

The request lines are levels held by the serial controller. No stream handshake exists at either edge of the block: requests carry no ready/valid pairing, and the vector is presented only while the CPU samples it. All inputs are taken as synchronous to `clk`. All outputs come from registers, so each output responds at the first rising edge that samples a new input condition.

Top module: `ivg_vector_gen`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `int_n` is 1, `vec_drive` is 0, `vec_data` is 0x00 and no source is masked.
- R2: Request bit i of `src_req` has vector 0x40 + 2*i. Bits 3..0 are channel B: bit 0 transmit empty (0x40), bit 1 status (0x42), bit 2 receive (0x44), bit 3 external (0x46). Bits 7..4 are channel A in the same kind order: 0x48, 0x4A, 0x4C, 0x4E.
- R3: After each rising edge, `int_n` is 0 if at least one unmasked request was high at that edge, and 1 otherwise.
- R4: When several unmasked requests are pending, the winner follows a fixed order from first to last: bits 6, 4, 7, 5, 2, 0, 3, 1. That is channel A before channel B, and within a channel receive, then transmit, then external, then status.
- R5: The winner is chosen at the first edge that samples the acknowledge condition. `vec_data` keeps that vector until the acknowledge ends, even if the requests change in between.
- R6: `vec_drive` rises at the first edge that samples an acknowledge with a source chosen. It falls at the first edge that samples the acknowledge gone. While `vec_drive` is 0, `vec_data` is 0x00.
- R7: The acknowledged source is masked from that same edge until an edge samples its request bit low. While masked, it neither holds `int_n` low nor wins an acknowledge, and the other sources are unaffected.
- R8: The acknowledge condition is `cpu_iorq_n`=0, `cpu_mreq_n`=1 and `cpu_m1_n`=0, all at the same time. Any other combination, including an opcode fetch (M1 and memory request low) or a plain I/O cycle (M1 high), is not an acknowledge.
- R9: An acknowledge that starts while no unmasked request is pending drives nothing (`vec_drive` stays 0) and masks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 8 | Level interrupt requests, bit map as in R2 |
| cpu_m1_n | input | 1 | CPU M1 strobe, active low |
| cpu_iorq_n | input | 1 | CPU I/O request strobe, active low |
| cpu_mreq_n | input | 1 | CPU memory request strobe, active low |
| int_n | output | 1 | Interrupt line to the CPU, active low |
| vec_data | output | 8 | Vector byte, 0x00 when not driven |
| vec_drive | output | 1 | Data-bus drive enable for the vector |

## Verification
The assertions check, on every cycle, the rules that can be judged from the ports alone. The drive enable may be high only one cycle after an acknowledge was decoded. A released bus reads zero. A driven vector stays stable and lies on the sparse even map. The interrupt line stays high when no request was present. Only the directed scenarios can show which source wins for a given pattern, that a held request stays silent after its acknowledge and re-arms once it drops, and that a late higher-priority request cannot change a vector already latched. They also show that near-miss strobe combinations are rejected.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

  localparam int CH_COUNT   = 2;
  localparam int SRC_PER_CH = 4;
  localparam int SRC_COUNT  = CH_COUNT * SRC_PER_CH;
  localparam int IDX_W      = $clog2(SRC_COUNT);

  typedef logic [IDX_W-1:0] src_idx_t;

  // Kind code is the source's position inside its channel's request nibble.
  typedef enum logic [1:0] {
    K_TX   = 2'd0,
    K_STAT = 2'd1,
    K_RX   = 2'd2,
    K_EXT  = 2'd3
  } src_kind_e;

  // Priority of kinds inside one channel, rank 0 first.
  function automatic src_kind_e kind_at_rank(input int unsigned k);
    case (k)
      0:       return K_RX;
      1:       return K_TX;
      2:       return K_EXT;
      default: return K_STAT;
    endcase
  endfunction

  // Source index for global rank r: highest channel first.
  function automatic src_idx_t src_at_rank(input int unsigned r);
    int unsigned ch;
    int unsigned kd;
    ch = (CH_COUNT - 1) - (r / SRC_PER_CH);
    kd = 32'(kind_at_rank(r % SRC_PER_CH));
    return src_idx_t'(ch * SRC_PER_CH + kd);
  endfunction

endpackage

// File: rtl/ivg_ack_detect.sv
module ivg_ack_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  input  logic iorq_n,
  input  logic mreq_n,
  output logic ack_now,
  output logic ack_start
);

  logic ack_q;

  // R8: acknowledge = I/O request and M1 low together, memory request idle
  assign ack_now   = !iorq_n && mreq_n && !m1_n;
  assign ack_start = ack_now && !ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_now;
  end

endmodule

// File: rtl/ivg_prio_pick.sv
module ivg_prio_pick
  import ivg_pkg::*;
#(
  parameter int N = SRC_COUNT
) (
  input  logic [N-1:0] pend,
  output src_idx_t     win_idx,
  output logic         win_any
);

  // Walk from lowest to highest rank so the highest rank overwrites last (R4).
  always_comb begin
    win_idx = '0;
    win_any = 1'b0;
    for (int r = N - 1; r >= 0; r--) begin
      if (pend[src_at_rank(r)]) begin
        win_idx = src_at_rank(r);
        win_any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ivg_mask_ctl.sv
module ivg_mask_ctl
  import ivg_pkg::*;
#(
  parameter int N = SRC_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         set_en,
  input  src_idx_t     set_idx,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_nxt
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    // R7: set on acknowledge, held while request stays high
    assign mask_nxt[i] = (mask_q[i] && req[i]) ||
                         (set_en && (set_idx == src_idx_t'(i)));

    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[i] <= 1'b0;
      else        mask_q[i] <= mask_nxt[i];
    end
  end

endmodule

// File: rtl/ivg_vector_gen.sv
module ivg_vector_gen
  import ivg_pkg::*;
#(
  parameter int          VEC_W      = 8,
  parameter logic [7:0]  VEC_BASE   = 8'h40,
  parameter int          STEP_SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] src_req,
  input  logic                 cpu_m1_n,
  input  logic                 cpu_iorq_n,
  input  logic                 cpu_mreq_n,
  output logic                 int_n,
  output logic [VEC_W-1:0]     vec_data,
  output logic                 vec_drive
);

  logic [SRC_COUNT-1:0] mask_q;
  logic [SRC_COUNT-1:0] mask_nxt;
  logic [SRC_COUNT-1:0] pend;
  src_idx_t             win_idx;
  logic                 win_any;
  logic                 ack_now;
  logic                 ack_start;
  logic                 set_en;
  src_idx_t             sel_q;
  logic                 drive_q;
  logic                 int_n_q;

  assign pend   = src_req & ~mask_q;
  assign set_en = ack_start && win_any;

  ivg_ack_detect u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .m1_n      (cpu_m1_n),
    .iorq_n    (cpu_iorq_n),
    .mreq_n    (cpu_mreq_n),
    .ack_now   (ack_now),
    .ack_start (ack_start)
  );

  ivg_prio_pick #(.N(SRC_COUNT)) u_pick (
    .pend    (pend),
    .win_idx (win_idx),
    .win_any (win_any)
  );

  ivg_mask_ctl #(.N(SRC_COUNT)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (src_req),
    .set_en   (set_en),
    .set_idx  (win_idx),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  // R5/R6/R9: latch winner at acknowledge start, drop drive when it ends
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      drive_q <= 1'b0;
    end else if (ack_start) begin
      sel_q   <= win_idx;
      drive_q <= win_any;
    end else if (!ack_now) begin
      drive_q <= 1'b0;
    end
  end

  // R3: uses next mask so an acknowledged source releases the line at once
  always_ff @(posedge clk) begin
    if (!rst_n) int_n_q <= 1'b1;
    else        int_n_q <= !(|(src_req & ~mask_nxt));
  end

  // R2: sparse even map from the base
  assign vec_data  = drive_q ? VEC_W'(VEC_BASE) + (VEC_W'(sel_q) << STEP_SHIFT)
                             : '0;
  assign vec_drive = drive_q;
  assign int_n     = int_n_q;

endmodule

// File: rtl/ivg_vector_gen_chk.sv
module ivg_vector_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] src_req,
  input logic       cpu_m1_n,
  input logic       cpu_iorq_n,
  input logic       cpu_mreq_n,
  input logic       int_n,
  input logic [7:0] vec_data,
  input logic       vec_drive
);

  logic ack_seen;
  assign ack_seen = !cpu_iorq_n && cpu_mreq_n && !cpu_m1_n;

  // R6 / R8: drive only after an acknowledge was sampled
  p_drive_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_drive |-> $past(ack_seen));

  // R6: released bus reads zero
  p_released_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_drive |-> (vec_data == 8'h00));

  // R5: vector frozen while driven
  p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_drive && $past(vec_drive)) |-> $stable(vec_data));

  // R2: driven vector lies on the even map 0x40..0x4E
  p_vec_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_drive |-> (vec_data[7:4] == 4'h4 && vec_data[0] == 1'b0));

  // R3: no request sampled means the line is idle
  p_int_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_req) == 8'h00) |-> int_n);

endmodule

bind ivg_vector_gen ivg_vector_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_req    (src_req),
  .cpu_m1_n   (cpu_m1_n),
  .cpu_iorq_n (cpu_iorq_n),
  .cpu_mreq_n (cpu_mreq_n),
  .int_n      (int_n),
  .vec_data   (vec_data),
  .vec_drive  (vec_drive)
);

// File: tb/sim_ivg_vector_gen.sv
`timescale 1ns/1ps
module sim_ivg_vector_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_req = 8'h00;
  logic       cpu_m1_n = 1'b1;
  logic       cpu_iorq_n = 1'b1;
  logic       cpu_mreq_n = 1'b1;
  logic       int_n;
  logic [7:0] vec_data;
  logic       vec_drive;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ivg_vector_gen u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .cpu_m1_n(cpu_m1_n), .cpu_iorq_n(cpu_iorq_n), .cpu_mreq_n(cpu_mreq_n),
    .int_n(int_n), .vec_data(vec_data), .vec_drive(vec_drive)
  );

  // Priority list first to last, taken from R4
  localparam int ORDER [8] = '{6, 4, 7, 5, 2, 0, 3, 1};

  function automatic logic [7:0] expect_vec(input logic [7:0] pat);
    for (int k = 7; k >= 0; k--) begin
      if (pat[ORDER[k]]) expect_vec = 8'h40 + 8'(ORDER[k] * 2);
    end
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ack_on();
    cpu_iorq_n = 1'b0; cpu_m1_n = 1'b0; cpu_mreq_n = 1'b1;
    tick();
  endtask

  task automatic ack_off();
    cpu_iorq_n = 1'b1; cpu_m1_n = 1'b1; cpu_mreq_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R1 int_n in reset", 8'(int_n), 8'h01);
    chk("R1 drive in reset", 8'(vec_drive), 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R1 int_n after reset", 8'(int_n), 8'h01);
    chk("R1 vec after reset", vec_data, 8'h00);
  endtask

  task automatic t_each_source();
    for (int i = 0; i < 8; i++) begin
      src_req = 8'(1 << i);
      tick();
      chk("R3 int_n low on request", 8'(int_n), 8'h00);
      ack_on();
      chk("R6 drive during ack", 8'(vec_drive), 8'h01);
      chk("R2 vector map", vec_data, 8'h40 + 8'(2 * i));
      ack_off();
      chk("R6 drive released", 8'(vec_drive), 8'h00);
      chk("R6 released vec zero", vec_data, 8'h00);
      chk("R7 held source masked", 8'(int_n), 8'h01);
      src_req = 8'h00;
      tick();
      chk("R3 int_n idle", 8'(int_n), 8'h01);
    end
  endtask

  task automatic t_priority();
    logic [7:0] pats [7] = '{8'hFF, 8'h0F, 8'h0B, 8'h0A, 8'h30, 8'hA2, 8'h22};
    for (int p = 0; p < 7; p++) begin
      src_req = pats[p];
      tick();
      ack_on();
      chk("R4 priority winner", vec_data, expect_vec(pats[p]));
      ack_off();
      src_req = 8'h00;
      tick();
    end
  endtask

  task automatic t_stable();
    src_req = 8'h01;
    tick();
    ack_on();
    chk("R5 first vector", vec_data, 8'h40);
    src_req = 8'h41;
    tick();
    chk("R5 vector held against late request", vec_data, 8'h40);
    chk("R5 drive held", 8'(vec_drive), 8'h01);
    ack_off();
    chk("R3 late request raises int_n", 8'(int_n), 8'h00);
    ack_on();
    chk("R5 late request served next", vec_data, 8'h4C);
    ack_off();
    src_req = 8'h00;
    tick();
  endtask

  task automatic t_mask();
    src_req = 8'h04;
    tick();
    ack_on();
    ack_off();
    repeat (4) tick();
    chk("R7 masked while held", 8'(int_n), 8'h01);
    ack_on();
    chk("R7 masked source not driven", 8'(vec_drive), 8'h00);
    ack_off();
    src_req = 8'h00;
    tick();
    src_req = 8'h04;
    tick();
    chk("R7 re-armed after drop", 8'(int_n), 8'h00);
    ack_on();
    chk("R7 re-armed vector", vec_data, 8'h44);
    ack_off();
    src_req = 8'h00;
    tick();
  endtask

  task automatic t_two_pending();
    src_req = 8'h11;
    tick();
    ack_on();
    chk("R4 first of two", vec_data, 8'h48);
    ack_off();
    chk("R7 other source still asserts", 8'(int_n), 8'h00);
    ack_on();
    chk("R7 second of two", vec_data, 8'h40);
    ack_off();
    chk("R7 both masked", 8'(int_n), 8'h01);
    src_req = 8'h00;
    tick();
  endtask

  task automatic t_decode();
    src_req = 8'h80;
    tick();
    cpu_iorq_n = 1'b0; cpu_m1_n = 1'b0; cpu_mreq_n = 1'b0;
    tick();
    chk("R8 memory request blocks ack", 8'(vec_drive), 8'h00);
    cpu_iorq_n = 1'b1; cpu_m1_n = 1'b0; cpu_mreq_n = 1'b0;
    tick();
    chk("R8 opcode fetch not ack", 8'(vec_drive), 8'h00);
    cpu_iorq_n = 1'b0; cpu_m1_n = 1'b1; cpu_mreq_n = 1'b1;
    tick();
    chk("R8 plain io not ack", 8'(vec_drive), 8'h00);
    chk("R8 request not masked by near miss", 8'(int_n), 8'h00);
    ack_off();
    ack_on();
    chk("R8 true ack vector", vec_data, 8'h4E);
    ack_off();
    src_req = 8'h00;
    tick();
  endtask

  task automatic t_spurious();
    src_req = 8'h00;
    tick();
    ack_on();
    chk("R9 no drive without request", 8'(vec_drive), 8'h00);
    src_req = 8'h02;
    tick();
    chk("R9 still no drive mid-ack", 8'(vec_drive), 8'h00);
    ack_off();
    chk("R9 request not masked", 8'(int_n), 8'h00);
    ack_on();
    chk("R9 later ack serves it", vec_data, 8'h42);
    ack_off();
    src_req = 8'h00;
    tick();
  endtask

  initial begin
    t_reset();
    t_each_source();
    t_priority();
    t_stable();
    t_mask();
    t_two_pending();
    t_decode();
    t_spurious();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule